// File: doc/BRIEF.md
# Serial SRAM sequential access engine

This engine lets a bit-serial datapath read and write a byte-addressed serial SRAM over a single shared data wire. The datapath presents and receives words least significant bit first. The memory expects the command byte, the address and the data most significant bit first. The engine keeps a word buffer that reverses the order in each direction. Every access carries a command byte and the full address, so any location costs the same number of clocks. A 32-bit word uses the memory's sequential mode and fills four consecutive bytes.

After reset the engine writes the memory's mode register once, to select sequential mode, before it accepts any request. Between frames the engine releases the data wire. A general-purpose input can then share that wire, and the engine samples it into a register on every idle cycle.

Top module: `sram_seq_engine`

## Requirements
- R1: After reset, before `ready` rises, the engine sends one frame holding command byte 0x01 and then mode byte 0x40, both MSB first. Chip select is low for 32 cycles during this frame. No `done` pulse follows it.
- R2: A `start` is ignored whenever `ready` is low, including during the boot frame and during any access.
- R3: When a write is accepted, `cpu_req` is high for W cycles (W = 16, or 32 when `wide` is set). The bench supplies the word on `cpu_sdi` LSB first, one bit per cycle, and chip select stays high during this phase.
- R4: An access frame carries command 0x03 (read) or 0x02 (write), then the 16 address bits MSB first, then W data bits MSB first. A 32-bit word occupies bytes addr..addr+3, with bits 31:24 at addr.
- R5: Each serial bit spans two cycles, with clock low and then clock high. Chip select is low for exactly 2*(24+W) cycles for a read or a write, at any address. For a write it falls in the cycle after the last `cpu_req` cycle. For a read it falls in the cycle after `start` is accepted.
- R6: After a read frame ends, `cpu_sdo_valid` is high for W cycles and `cpu_sdo` delivers the word LSB first.
- R7: `done` is high for one cycle right after the frame (write) or right after the last delivered bit (read). `ready` is high from the following cycle.
- R8: The engine drives the data wire only while chip select is low, and not during the data bits of a read. `idle_in` registers the wire level on every cycle in which `ready` is high and holds that value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an access (taken when ready) |
| wr | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 32-bit word, 0 = 16-bit word |
| addr | input | 16 | Byte address, captured with start |
| cpu_sdi | input | 1 | Write data bit from the datapath, LSB first |
| cpu_req | output | 1 | Engine takes one cpu_sdi bit this cycle |
| cpu_sdo | output | 1 | Read data bit to the datapath, LSB first |
| cpu_sdo_valid | output | 1 | cpu_sdo carries a read bit this cycle |
| ready | output | 1 | Engine idle, start will be taken |
| done | output | 1 | One-cycle completion pulse |
| idle_in | output | 1 | Registered level of the shared wire while idle |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_sck | output | 1 | Memory serial clock |
| mem_sio | inout | 1 | Shared serial data wire |

## Verification
Two functions can fall in the same cycle. One is the idle sampling of the shared wire. The other is the acceptance of a new request, which hands the wire over to the engine. The bench drives the wire to a known level in exactly the cycle it raises `start`, and releases it one cycle later. It then requires `idle_in` to keep that level through the whole access and to follow a new level only once the engine is idle again. The bench also raises `start` while the boot frame and a write frame are in progress. A per-cycle schedule of chip select, `ready`, `done`, `cpu_req` and `cpu_sdo_valid` judges that these requests change nothing, together with the byte contents of a behavioural memory.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
    localparam int CMD_W     = 8;
    localparam int BOOT_BITS = 16;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_MODE  = 8'h01;
    localparam logic [7:0] MODE_SEQ  = 8'h40;

    typedef enum logic [2:0] {
        ST_BOOT, ST_IDLE, ST_LOAD, ST_SHIFT, ST_UNLOAD, ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic wr;
        logic wide;
        logic boot;
    } xfer_t;

    function automatic int word_bits(input logic wide, input int dw);
        return wide ? 2 * dw : dw;
    endfunction
endpackage

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int CNT_W = $clog2(CMD_W + AW + 2 * DW + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wr,
    input  logic       wide,
    output eng_state_e st,
    output xfer_t      xfer,
    output logic       ph,
    output logic       accept,
    output logic       frame_ld,
    output logic       shift_step,
    output logic       drive_en
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_word;
    logic [CNT_W-1:0] last_frame;

    always_comb begin
        last_word  = CNT_W'(word_bits(xfer.wide, DW) - 1);
        last_frame = xfer.boot ? CNT_W'(BOOT_BITS - 1)
                               : CNT_W'(CMD_W + AW) + last_word;
    end

    assign accept     = (st == ST_IDLE) && start;
    assign frame_ld   = (st == ST_BOOT) || (accept && !wr)
                      || ((st == ST_LOAD) && (cnt == last_word));
    assign shift_step = (st == ST_SHIFT) && ph;
    assign drive_en   = (st == ST_SHIFT)
                      && (xfer.wr || xfer.boot || (cnt < CNT_W'(CMD_W + AW)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_BOOT;
            ph   <= 1'b0;
            cnt  <= '0;
            xfer <= '{wr: 1'b0, wide: 1'b0, boot: 1'b1};
        end else begin
            unique case (st)
                ST_BOOT: begin
                    st        <= ST_SHIFT;
                    ph        <= 1'b0;
                    cnt       <= '0;
                    xfer.boot <= 1'b1;
                end
                ST_IDLE: begin
                    if (start) begin
                        xfer <= '{wr: wr, wide: wide, boot: 1'b0};
                        cnt  <= '0;
                        ph   <= 1'b0;
                        st   <= wr ? ST_LOAD : ST_SHIFT;
                    end
                end
                ST_LOAD, ST_UNLOAD: begin
                    if (cnt == last_word) begin
                        cnt <= '0;
                        st  <= (st == ST_LOAD) ? ST_SHIFT : ST_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (cnt == last_frame) begin
                            cnt <= '0;
                            st  <= xfer.boot ? ST_IDLE
                                 : (xfer.wr ? ST_DONE : ST_UNLOAD);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_seq_tx.sv
`timescale 1ns/1ps
module sram_seq_tx
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] addr,
    input  logic          cap_en,
    input  logic          cpu_sdi,
    input  logic          frame_ld,
    input  logic          ld_boot,
    input  logic          ld_wr,
    input  logic          ld_wide,
    input  logic          shift_step,
    output logic          tx_bit
);
    localparam int RW = 2 * DW;
    localparam int FW = CMD_W + AW + RW;

    logic [AW-1:0] addr_q;
    logic [RW-1:0] gbuf, gnext, data_field;
    logic [FW-1:0] txsr, frame;

    // LSB-first arrivals shift in from the top, so the word ends up MSB-aligned
    assign gnext      = {cpu_sdi, gbuf[RW-1:1]};
    assign data_field = ld_wide ? gnext : {gnext[RW-1:DW], {DW{1'b0}}};

    always_comb begin
        if (ld_boot)
            frame = {CMD_MODE, MODE_SEQ, {(FW - 16){1'b0}}};
        else if (ld_wr)
            frame = {CMD_WRITE, addr_q, data_field};
        else
            frame = {CMD_READ, addr, {RW{1'b0}}};
    end

    assign tx_bit = txsr[FW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            gbuf   <= '0;
            txsr   <= '0;
        end else begin
            if (accept)
                addr_q <= addr;
            if (cap_en)
                gbuf <= gnext;
            if (frame_ld)
                txsr <= frame;
            else if (shift_step)
                txsr <= {txsr[FW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sram_seq_rx.sv
`timescale 1ns/1ps
module sram_seq_rx #(
    parameter int DW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_en,
    input  logic sio_in,
    input  logic unload_en,
    output logic rx_bit
);
    localparam int RW = 2 * DW;

    logic [RW-1:0] rx;

    // MSB-first bits enter at bit 0; unloading shifts right so bit 0 leaves first
    assign rx_bit = rx[0];

    always_ff @(posedge clk) begin
        if (rst || clear)
            rx <= '0;
        else if (sample_en)
            rx <= {rx[RW-2:0], sio_in};
        else if (unload_en)
            rx <= {1'b0, rx[RW-1:1]};
    end
endmodule

// File: rtl/sram_seq_engine.sv
`timescale 1ns/1ps
module sram_seq_engine
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wr,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic          cpu_sdi,
    output logic          cpu_req,
    output logic          cpu_sdo,
    output logic          cpu_sdo_valid,
    output logic          ready,
    output logic          done,
    output logic          idle_in,
    output logic          mem_cs_n,
    output logic          mem_sck,
    inout  wire           mem_sio
);
    eng_state_e st;
    xfer_t      xfer;
    logic       ph, accept, frame_ld, shift_step, drive_en, tx_bit, sio_in;

    sram_seq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .wide(wide),
        .st(st), .xfer(xfer), .ph(ph), .accept(accept), .frame_ld(frame_ld),
        .shift_step(shift_step), .drive_en(drive_en)
    );

    sram_seq_tx #(.AW(AW), .DW(DW)) u_tx (
        .clk(clk), .rst(rst), .accept(accept), .addr(addr),
        .cap_en(st == ST_LOAD), .cpu_sdi(cpu_sdi), .frame_ld(frame_ld),
        .ld_boot(st == ST_BOOT), .ld_wr(st == ST_LOAD), .ld_wide(xfer.wide),
        .shift_step(shift_step), .tx_bit(tx_bit)
    );

    sram_seq_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst(rst), .clear(frame_ld), .sample_en(shift_step),
        .sio_in(sio_in), .unload_en(st == ST_UNLOAD), .rx_bit(cpu_sdo)
    );

    assign mem_sio       = drive_en ? tx_bit : 1'bz;
    assign sio_in        = mem_sio;
    assign mem_cs_n      = (st != ST_SHIFT);
    assign mem_sck       = (st == ST_SHIFT) && ph;
    assign cpu_req       = (st == ST_LOAD);
    assign cpu_sdo_valid = (st == ST_UNLOAD);
    assign ready         = (st == ST_IDLE);
    assign done          = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst)
            idle_in <= 1'b0;
        else if (st == ST_IDLE)
            idle_in <= sio_in;
    end
endmodule

// File: rtl/sram_seq_engine_chk.sv
`timescale 1ns/1ps
module sram_seq_engine_chk (
    input logic clk,
    input logic rst,
    input logic mem_cs_n,
    input logic mem_sck,
    input logic done,
    input logic ready,
    input logic cpu_req,
    input logic cpu_sdo_valid,
    input logic drive_en
);
    assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        mem_sck |-> !mem_cs_n);
    assert_sck_starts_low_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> !mem_sck);
    assert_sck_alternates_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_sck != $past(mem_sck)));
    assert_gather_outside_frame_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (mem_cs_n && !cpu_sdo_valid && !ready));
    assert_unload_outside_frame_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_sdo_valid |-> mem_cs_n);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_then_ready_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_cs_n ##1 ready);
    assert_drive_only_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> !mem_cs_n);
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_cs_n && !drive_en));
endmodule

bind sram_seq_engine sram_seq_engine_chk u_chk (
    .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_sck(mem_sck),
    .done(done), .ready(ready), .cpu_req(cpu_req),
    .cpu_sdo_valid(cpu_sdo_valid), .drive_en(drive_en)
);

// File: tb/sram_seq_engine_bench.sv
`timescale 1ns/1ps
module sram_seq_engine_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, wr = 1'b0, wide = 1'b0, cpu_sdi = 1'b0;
    logic [15:0] addr = '0;
    logic cpu_req, cpu_sdo, cpu_sdo_valid, ready, done, idle_in, mem_cs_n, mem_sck;
    wire  mem_sio;
    logic mdl_oe = 1'b0, mdl_d = 1'b0, ext_oe = 1'b0, ext_d = 1'b0;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 1'b0;

    // expected per cycle: {cs_n, ready, done, req, valid}
    localparam logic [4:0] E_IDLE = 5'b11000, E_LOAD = 5'b10010,
                           E_SHIFT = 5'b00000, E_UNLD = 5'b10001, E_DONE = 5'b10100;
    logic [4:0] exp_q[$];
    logic       rd_q[$];

    // behavioural memory
    logic [7:0]  mem[int];
    logic [7:0]  m_cmd, m_mode, m_byte;
    logic [15:0] m_addr;
    int          m_cnt;

    always #2.5 clk = ~clk;

    assign mem_sio = (mdl_oe | ext_oe) ? (mdl_oe ? mdl_d : ext_d) : 1'bz;

    sram_seq_engine u_sram_seq_engine (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .wide(wide), .addr(addr),
        .cpu_sdi(cpu_sdi), .cpu_req(cpu_req), .cpu_sdo(cpu_sdo),
        .cpu_sdo_valid(cpu_sdo_valid), .ready(ready), .done(done),
        .idle_in(idle_in), .mem_cs_n(mem_cs_n), .mem_sck(mem_sck), .mem_sio(mem_sio)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge mem_cs_n) begin
        m_cnt = 0; m_cmd = '0; m_addr = '0;
    end
    always @(posedge mem_cs_n) mdl_oe = 1'b0;

    always @(posedge mem_sck) if (!mem_cs_n) begin
        if (m_cnt < 8) m_cmd = {m_cmd[6:0], mem_sio};
        else if (m_cmd == 8'h01) m_mode = {m_mode[6:0], mem_sio};
        else if (m_cnt < 24) m_addr = {m_addr[14:0], mem_sio};
        else if (m_cmd == 8'h02) begin
            m_byte = {m_byte[6:0], mem_sio};
            if ((m_cnt - 24) % 8 == 7)
                mem[int'(16'(m_addr + 16'((m_cnt - 24) / 8)))] = m_byte;
        end
        m_cnt++;
    end

    always @(negedge mem_sck) if (!mem_cs_n && m_cmd == 8'h03 && m_cnt >= 24) begin
        int a;
        int k;
        k = m_cnt - 24;
        a = int'(16'(m_addr + 16'(k / 8)));
        mdl_d  = mem.exists(a) ? mem[a][7 - (k % 8)] : 1'b0;
        mdl_oe = 1'b1;
    end

    // per-cycle comparison against the schedule
    always @(negedge clk) if (!rst && !finished) begin
        logic [4:0] e;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : E_IDLE;
        chk(mem_cs_n == e[4], "R5 chip select", 32'(mem_cs_n), 32'(e[4]));
        chk(ready == e[3], "R7 ready", 32'(ready), 32'(e[3]));
        chk(done == e[2], "R7 done", 32'(done), 32'(e[2]));
        chk(cpu_req == e[1], "R3 cpu_req", 32'(cpu_req), 32'(e[1]));
        chk(cpu_sdo_valid == e[0], "R6 cpu_sdo_valid", 32'(cpu_sdo_valid), 32'(e[0]));
        if (cpu_sdo_valid) rd_q.push_back(cpu_sdo);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run(input bit w, input bit wd, input logic [15:0] a,
                       input logic [31:0] v, input bit probe, input bit poke,
                       output logic [31:0] got);
        int nb;
        nb = wd ? 32 : 16;
        @(negedge clk);
        while (!ready) @(negedge clk);
        #1;
        rd_q.delete();
        start = 1'b1; wr = w; wide = wd; addr = a;
        if (probe) begin ext_oe = 1'b1; ext_d = 1'b1; end
        if (w) for (int i = 0; i < nb; i++) exp_q.push_back(E_LOAD);
        for (int i = 0; i < 2 * (24 + nb); i++) exp_q.push_back(E_SHIFT);
        if (!w) for (int i = 0; i < nb; i++) exp_q.push_back(E_UNLD);
        exp_q.push_back(E_DONE);
        @(negedge clk); #1;
        start = 1'b0; ext_oe = 1'b0; wr = ~w; wide = ~wd; addr = ~a;
        if (w) begin
            cpu_sdi = v[0];
            for (int k = 1; k < nb; k++) begin
                @(negedge clk); #1;
                cpu_sdi = v[k];
            end
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            #1; start = 1'b1;
            repeat (3) @(negedge clk);
            #1; start = 1'b0;
        end
        while (exp_q.size() != 0) begin
            @(negedge clk); #1;
        end
        got = '0;
        for (int i = 0; i < rd_q.size(); i++) got[i] = rd_q[i];
    endtask

    function automatic logic [7:0] mb(input int a);
        return mem.exists(a) ? mem[a] : 8'hxx;
    endfunction

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        chk(mem_cs_n == 1'b1, "R1 reset cs_n", 32'(mem_cs_n), 32'd1);
        chk(ready == 1'b0, "R1 reset ready", 32'(ready), 32'd0);
        chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        #1;
        for (int i = 0; i < 32; i++) exp_q.push_back(E_SHIFT);
        rst = 1'b0;
        // R2: requests during the boot frame
        repeat (4) @(negedge clk);
        #1; start = 1'b1; wr = 1'b1;
        repeat (5) @(negedge clk);
        #1; start = 1'b0; wr = 1'b0;
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        chk(m_cmd == 8'h01, "R1 boot command", 32'(m_cmd), 32'h01);
        chk(m_mode == 8'h40, "R1 mode byte", 32'(m_mode), 32'h40);
        chk(mem.num() == 0, "R2 no write from boot-time start", mem.num(), 0);

        run(1'b1, 1'b0, 16'h0000, 32'h0000_A5C3, 1'b0, 1'b0, got);
        chk(m_cmd == 8'h02, "R4 write command", 32'(m_cmd), 32'h02);
        chk(mb(0) == 8'hA5, "R4 byte 0x0000", 32'(mb(0)), 32'hA5);
        chk(mb(1) == 8'hC3, "R4 byte 0x0001", 32'(mb(1)), 32'hC3);
        run(1'b0, 1'b0, 16'h0000, 32'h0, 1'b0, 1'b0, got);
        chk(m_cmd == 8'h03, "R4 read command", 32'(m_cmd), 32'h03);
        chk(got == 32'h0000_A5C3, "R6 read 0x0000", got, 32'h0000_A5C3);

        run(1'b1, 1'b0, 16'hFFFE, 32'h0000_1E0F, 1'b0, 1'b1, got);
        chk(mb(16'hFFFE) == 8'h1E, "R4 byte 0xFFFE", 32'(mb(16'hFFFE)), 32'h1E);
        chk(mb(16'hFFFF) == 8'h0F, "R4 byte 0xFFFF", 32'(mb(16'hFFFF)), 32'h0F);
        chk(mem.num() == 4, "R2 mid-frame start left no extra write", mem.num(), 4);
        run(1'b0, 1'b0, 16'hFFFE, 32'h0, 1'b0, 1'b0, got);
        chk(got == 32'h0000_1E0F, "R6 read 0xFFFE", got, 32'h0000_1E0F);

        run(1'b1, 1'b1, 16'h8001, 32'hDEAD_BEEF, 1'b0, 1'b0, got);
        chk(mb(16'h8001) == 8'hDE, "R4 wide byte 0", 32'(mb(16'h8001)), 32'hDE);
        chk(mb(16'h8002) == 8'hAD, "R4 wide byte 1", 32'(mb(16'h8002)), 32'hAD);
        chk(mb(16'h8003) == 8'hBE, "R4 wide byte 2", 32'(mb(16'h8003)), 32'hBE);
        chk(mb(16'h8004) == 8'hEF, "R4 wide byte 3", 32'(mb(16'h8004)), 32'hEF);
        run(1'b0, 1'b1, 16'h8001, 32'h0, 1'b0, 1'b0, got);
        chk(got == 32'hDEAD_BEEF, "R6 wide read", got, 32'hDEAD_BEEF);
        run(1'b0, 1'b0, 16'h8003, 32'h0, 1'b1, 1'b0, got);
        chk(got == 32'h0000_BEEF, "R4 sequential upper half", got, 32'h0000_BEEF);
        chk(idle_in == 1'b1, "R8 sample at accept held", 32'(idle_in), 32'd1);

        @(negedge clk); #1; ext_oe = 1'b1; ext_d = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(idle_in == 1'b0, "R8 idle sample low", 32'(idle_in), 32'd0);
        #1; ext_d = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(idle_in == 1'b1, "R8 idle sample high", 32'(idle_in), 32'd1);
        #1; ext_oe = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule